// File: doc/BRIEF.md
# Word Serializer with Internal Wrap

This block turns a stream of 20-bit words into a serial bit stream. Each word holds two 10-bit transmission characters that are already line-coded. A word enters on a rising edge of a word clock. It is then sent one bit per bit-rate enable cycle, so twenty enable cycles carry one word. The core clock `clk` runs at or above the bit rate. The bit-rate enable `bit_en` stands in for a synthesized high-speed clock. The word clock must have exactly twenty `bit_en` pulses per period.

Two controls act on the line pair `tx_p`/`tx_n`:
- `tx_off` is an active-high transmit disable.
- `wrap_en` selects internal wrap.

When either control is high, the line rests at its idle level. In wrap mode the serial stream also replaces the external receive input on `rx_data`. This lets the receive path be exercised without a cable.

Top module: `ser_tx_wrap`

## Requirements
- R1: `tx_word` is captured at the first `clk` edge at which `word_clk` is sampled high after being sampled low.
- R2: The bit position advances only on `clk` edges where `bit_en` is 1. Each word occupies exactly 20 such edges, whatever the spacing of the enables.
- R3: Bit 0 of the captured word is sent first and bit 19 last. Bits 0..9 form the first character, with bit 0 being coding position a, and bits 10..19 form the second character.
- R4: After the first capture, bit 0 of that word appears on the line right after the next `bit_en` edge. Each further word is loaded on the `bit_en` edge that follows its bit 19, so words follow back to back with no gap.
- R5: While `wrap_en` or `tx_off` is 1, `tx_p` is 1 and `tx_n` is 0, combinationally.
- R6: While both `wrap_en` and `tx_off` are 0, `tx_p` equals the current stream bit and `tx_n` is its complement.
- R7: While `wrap_en` is 1, `rx_data` equals the current stream bit. While it is 0, `rx_data` equals `rx_line`.
- R8: From reset until the first word is loaded, the stream bit is 1, so `tx_p` is 1 and `tx_n` is 0.
- R9: If no new rising edge of `word_clk` arrives during a word, the most recently captured word is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at or above the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| word_clk | input | 1 | Word clock; rising level change captures `tx_word` |
| tx_word | input | 20 | Two coded characters; bit 0 is sent first |
| tx_off | input | 1 | Transmit disable, active high |
| wrap_en | input | 1 | Internal wrap; holds line idle, loops stream back |
| rx_line | input | 1 | Serial bit from the external receive line |
| tx_p | output | 1 | Line output, true polarity |
| tx_n | output | 1 | Line output, complement polarity |
| rx_data | output | 1 | Serial bit handed to the receive path |

## Verification
The stream is exercised with the following words: all ones, all zeros, alternating bits, a comma-bearing pair and two irregular words.
- The uniform words separate the idle level from real data.
- The alternating and irregular words expose swapped, reversed or skipped bit positions.

Each word series is repeated with an enable on every cycle, every second cycle and every third cycle, which separates bit timing tied to `bit_en` from timing tied to `clk`. Disable and wrap windows sit inside live words, and `rx_line` toggles throughout, so the muxing of line and loopback is checked against data that differs from the idle level. One word period with no word-clock edge shows that the last captured word is sent again.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // last bit position of a word of the given width
  function automatic int unsigned last_pos(input int unsigned width);
    return width - 1;
  endfunction

  // line value for a given stream bit and disable state
  function automatic logic line_level(input logic stream_bit, input logic disabled);
    return disabled ? 1'b1 : stream_bit;
  endfunction
endpackage

// File: rtl/ser_word_cap.sv
module ser_word_cap #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_clk,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] cap_q,
  output logic         cap_valid,
  output logic         cap_stb
);
  logic wclk_q;

  assign cap_stb = word_clk & ~wclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q    <= 1'b0;
      cap_q     <= '0;
      cap_valid <= 1'b0;
    end else begin
      wclk_q <= word_clk;
      if (cap_stb) begin
        cap_q     <= word_in;
        cap_valid <= 1'b1;
      end
    end
  end

  AST_CAP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (cap_q == $past(word_in)) && cap_valid); // R1
  AST_CAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(cap_q)); // R9
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ser_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic [W-1:0] cap_q,
  input  logic         cap_valid,
  output logic         stream_bit,
  output logic         running,
  output logic         load_stb
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(last_pos(W));

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last    = (cnt == LAST);
  assign load_stb   = bit_en & cap_valid & (~running | at_last);
  assign stream_bit = running ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      running <= 1'b0;
    end else if (load_stb) begin
      shreg   <= cap_q;
      cnt     <= '0;
      running <= 1'b1;
    end else if (bit_en && running) begin
      shreg <= {1'b0, shreg[W-1:1]};
      cnt   <= cnt + CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(shreg) && $stable(cnt)); // R2
  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && running && !at_last) |=> shreg[W-2:0] == $past(shreg[W-1:1])); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && running && at_last) |=> (cnt == '0) && (shreg == $past(cap_q))); // R4
endmodule

// File: rtl/ser_line_mux.sv
module ser_line_mux
  import ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stream_bit,
  input  logic wrap_en,
  input  logic tx_off,
  input  logic rx_line,
  output logic tx_p,
  output logic tx_n,
  output logic rx_data
);
  logic disabled;

  assign disabled = wrap_en | tx_off;
  assign tx_p     = line_level(stream_bit, disabled);
  assign tx_n     = ~tx_p;
  assign rx_data  = wrap_en ? stream_bit : rx_line;

  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en || tx_off) |-> (tx_p && !tx_n)); // R5
  AST_LINE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en && !tx_off) |-> (tx_p == stream_bit) && (tx_n != tx_p)); // R6
  AST_WRAP_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_en |-> (rx_data == stream_bit)); // R7
endmodule

// File: rtl/ser_tx_wrap.sv
module ser_tx_wrap #(
  parameter int unsigned CHAR_W  = 10,
  parameter int unsigned N_CHARS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_en,
  input  logic                       word_clk,
  input  logic [CHAR_W*N_CHARS-1:0]  tx_word,
  input  logic                       tx_off,
  input  logic                       wrap_en,
  input  logic                       rx_line,
  output logic                       tx_p,
  output logic                       tx_n,
  output logic                       rx_data
);
  localparam int unsigned W = CHAR_W * N_CHARS;

  logic [W-1:0] cap_q;
  logic         cap_valid;
  logic         cap_stb;
  logic         stream_bit;
  logic         running;
  logic         load_stb;

  ser_word_cap #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .word_clk(word_clk), .word_in(tx_word),
    .cap_q(cap_q), .cap_valid(cap_valid), .cap_stb(cap_stb)
  );

  ser_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cap_q(cap_q),
    .cap_valid(cap_valid), .stream_bit(stream_bit), .running(running),
    .load_stb(load_stb)
  );

  ser_line_mux u_mux (
    .clk(clk), .rst_n(rst_n), .stream_bit(stream_bit), .wrap_en(wrap_en),
    .tx_off(tx_off), .rx_line(rx_line), .tx_p(tx_p), .tx_n(tx_n),
    .rx_data(rx_data)
  );

  AST_PRELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (stream_bit && tx_p && !tx_n)); // R8
  AST_LOAD_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (cap_valid && bit_en)); // R4
endmodule

// File: tb/tb_ser_tx_wrap.sv
`timescale 1ns/1ps
module tb_ser_tx_wrap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        word_clk = 1'b0;
  logic [19:0] tx_word = '0;
  logic        tx_off = 1'b0;
  logic        wrap_en = 1'b0;
  logic        rx_line = 1'b0;
  logic        tx_p, tx_n, rx_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ser_tx_wrap dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_clk(word_clk),
    .tx_word(tx_word), .tx_off(tx_off), .wrap_en(wrap_en), .rx_line(rx_line),
    .tx_p(tx_p), .tx_n(tx_n), .rx_data(rx_data)
  );

  function automatic logic [19:0] word_of(input int k);
    case (k)
      0: return 20'hFFFFF;
      1: return 20'h00000;
      2: return 20'hAAAAA;
      3: return 20'h5C3E7;
      4: return 20'h8F1E3;
      5: return 20'h36C9B;
      6: return 20'h0F83E;
      default: return 20'h13579;
    endcase
  endfunction

  // word 5 is never presented with a rising edge: the previous word repeats (R9)
  function automatic logic [19:0] sent_word(input int k);
    return (k == 5) ? word_of(4) : word_of(k);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic run(input int div);
    int cyc = 0;
    int nxt = 0;
    int cur = -1;
    rst_n = 1'b0; bit_en = 1'b0; word_clk = 1'b0; tx_word = '0;
    wrap_en = 1'b0; tx_off = 1'b0; rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_p, 1'b1, "R8", "tx_p after reset");
    check(tx_n, 1'b0, "R8", "tx_n after reset");
    while (cur < 140) begin
      bit_en = ((cyc % div) == 0);
      if (bit_en) begin
        int m = nxt;
        int wk = m / 20;
        word_clk = ((m % 20) < 10) && (wk != 5);
        tx_word  = word_of(wk);
        rx_line  = ((m % 3) == 0);
        if (m >= 1) begin
          int k = (m - 1) / 20;
          int j = (m - 1) % 20;
          wrap_en = (k == 3) && (j >= 5) && (j < 15);
          tx_off  = (k == 4) && (j < 10);
        end
      end
      @(negedge clk);
      if (bit_en) begin
        cur = nxt;
        nxt++;
      end
      cyc++;
      begin
        logic eb, dis, ep;
        int k, j;
        string tag;
        k = (cur >= 1) ? (cur - 1) / 20 : 0;
        j = (cur >= 1) ? (cur - 1) % 20 : 0;
        eb  = (cur < 1) ? 1'b1 : sent_word(k)[j];
        dis = wrap_en | tx_off;
        ep  = dis ? 1'b1 : eb;
        if (cur < 1)       tag = "R8";
        else if (dis)      tag = "R5";
        else if (k == 5)   tag = "R9";
        else if (div > 1)  tag = "R2";
        else if (k == 0)   tag = "R1";
        else if (j == 0)   tag = "R4";
        else               tag = "R3";
        check(tx_p, ep, tag, "tx_p");
        check(tx_n, ~ep, dis ? "R5" : "R6", "tx_n");
        check(rx_data, wrap_en ? eb : rx_line, "R7", "rx_data");
      end
    end
  endtask

  initial begin
    run(1);
    run(2);
    run(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule